// File: doc/BRIEF.md
# I2C 8-bit Port Expander Target

This block is an I2C target that exposes an 8-bit general-purpose port through four byte-wide registers. SCL and SDA are oversampled by a fast system clock, passed through a synchronizer, and turned into edge events and START, repeated START and STOP conditions. The block acknowledges its own 7-bit address. The first data byte written after that address becomes a register pointer, and every later data byte in the same transfer lands in the register the pointer selects.

A read is done in two parts. The master writes the pointer, issues a repeated START, and sends the address again with the read bit set. The block then returns the selected register on every read byte until the master answers with a NACK. The port pins carry per-bit output enables that come from the direction register. Input pins pass through a synchronizer and a per-bit polarity inversion before they can be read.

Top module: `ioexp_target`

## Requirements
- R1: After reset, `port_out` is 0xFF, `port_oe` is 0x00 (every pin is an input) and `sda_oe` is 0 (SDA released).
- R2: The block acknowledges only the 7-bit address 0b010000 followed by `addr_sel` as its low bit (0x20 or 0x21). Any other address gets a NACK and is ignored until the next START.
- R3: After a START and a matching address with R/W = 0, the first data byte is acknowledged and becomes the register pointer.
- R4: Every further data byte written before STOP is acknowledged and written to the selected register. The pointer does not advance, so with several bytes the last one is the value that remains.
- R5: Register map by pointer: 0 reads the input port, 1 is the output value, 2 is polarity inversion, 3 is direction. The sequence pointer write, repeated START, address with R/W = 1 returns the selected register, MSB first, on every read byte.
- R6: `port_out` equals the output register. Bit i of `port_oe` is the inverse of direction bit i, so a 1 in the direction register makes the pin an input. The direction register resets to 0xFF.
- R7: Reading pointer 0 returns each synchronized `port_in` bit XOR its polarity bit. The polarity register resets to 0x00.
- R8: A write with pointer 0 is acknowledged and changes no register.
- R9: A pointer above 3 is acknowledged. Writes through it are discarded and reads through it return 0xFF.
- R10: A STOP returns the block to idle from any state, including in the middle of a byte. A byte cut off by a STOP writes nothing.
- R11: After the master NACKs a read byte, the block keeps SDA released until the next START or STOP.
- R12: Bits are sampled on rising SCL. The block starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 1 | Low bit of the target address |
| port_in | input | 8 | Port pin levels |
| port_out | output | 8 | Port output values |
| port_oe | output | 8 | Per-pin output enable, 1 drives the pin |

## Verification
Directed transfers write one register with a burst of bytes and then read back every register. This separates a pointer that stays put from one that advances, and shows that writes to one register do not spill into another. Input reads use pin and polarity patterns with mixed ones and zeros, so an XOR cannot be confused with a plain copy or an inverse. Foreign addresses, both `addr_sel` settings, pointers 0 and 7, STOPs in mid-byte and a master NACK followed by extra clocks each test one corner. Seeded random write-then-read transfers against a register model cover the remaining combinations.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK,
      ST_RLOAD,
      ST_HOLD
   } bus_st_e;

   localparam int unsigned REG_IN  = 0;
   localparam int unsigned REG_OUT = 1;
   localparam int unsigned REG_POL = 2;
   localparam int unsigned REG_CFG = 3;
   localparam int unsigned REG_CNT = 4;

endpackage

// File: rtl/ioexp_sync.sv
module ioexp_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic        RST_V  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= {W{RST_V}};
            else        stg_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= {W{RST_V}};
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ioexp_linecond.sv
module ioexp_linecond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ioexp_busfsm.sv
module ioexp_busfsm
   import ioexp_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter logic [5:0]  ADDR_HI = 6'b010000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scl_s,
   input  logic         sda_s,
   input  logic         scl_rise,
   input  logic         scl_fall,
   input  logic         start_det,
   input  logic         stop_det,
   input  logic         addr_sel,
   input  logic [W-1:0] rd_data,
   output logic [W-1:0] ptr,
   output logic         wr_en,
   output logic [W-1:0] wr_data,
   output logic         sda_oe
);

   localparam int unsigned BW = $clog2(W + 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);
   localparam logic [BW-1:0] ALL_BITS = BW'(W);

   bus_st_e       st, nxt;
   logic [BW-1:0] bcnt;
   logic [W-1:0]  sh;
   logic          ack_on;
   logic [W-1:0]  byte_in;
   logic [6:0]    own_addr;

   assign byte_in  = {sh[W-2:0], sda_s};
   assign own_addr = {ADDR_HI, addr_sel};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         nxt     <= ST_IDLE;
         bcnt    <= '0;
         sh      <= '0;
         ack_on  <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
            ack_on <= 1'b0;
         end else if (start_det) begin
            st     <= ST_ADDR;
            bcnt   <= '0;
            sda_oe <= 1'b0;
            ack_on <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (scl_rise) begin
                     sh   <= byte_in;
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == LAST_BIT) begin
                        ack_on <= 1'b0;
                        if (st == ST_ADDR) begin
                           if (byte_in[W-1:1] == own_addr) begin
                              st  <= ST_ACK;
                              nxt <= byte_in[0] ? ST_RDATA : ST_PTR;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end else if (st == ST_PTR) begin
                           ptr <= byte_in;
                           st  <= ST_ACK;
                           nxt <= ST_WDATA;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_data <= byte_in;
                           st      <= ST_ACK;
                           nxt     <= ST_WDATA;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (!ack_on) begin
                        ack_on <= 1'b1;
                        sda_oe <= 1'b1;
                     end else begin
                        ack_on <= 1'b0;
                        bcnt   <= '0;
                        if (nxt == ST_RDATA) begin
                           sh     <= rd_data;
                           sda_oe <= ~rd_data[W-1];
                           st     <= ST_RDATA;
                        end else begin
                           sda_oe <= 1'b0;
                           st     <= nxt;
                        end
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bcnt == ALL_BITS) begin
                        sda_oe <= 1'b0;
                        st     <= ST_RACK;
                     end else begin
                        sh     <= {sh[W-2:0], 1'b0};
                        sda_oe <= ~sh[W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) st <= sda_s ? ST_HOLD : ST_RLOAD;
               end
               ST_RLOAD: begin
                  if (scl_fall) begin
                     bcnt   <= '0;
                     sh     <= rd_data;
                     sda_oe <= ~rd_data[W-1];
                     st     <= ST_RDATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12
   drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R10
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (st == ST_IDLE) && !sda_oe);

   // R11
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD) |-> !sda_oe);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R4
   ptr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WDATA || st == ST_RDATA) |=> $stable(ptr));

endmodule

// File: rtl/ioexp_regs.sv
module ioexp_regs
   import ioexp_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] ptr,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] pin_s,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] port_out,
   output logic [W-1:0] port_oe
);

   logic [W-1:0] out_q, pol_q, cfg_q;
   logic         ptr_ok;

   assign ptr_ok = (ptr < W'(REG_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '1;
         pol_q <= '0;
         cfg_q <= '1;
      end else if (wr_en && ptr_ok) begin
         case (ptr)
            W'(REG_OUT): out_q <= wr_data;
            W'(REG_POL): pol_q <= wr_data;
            W'(REG_CFG): cfg_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_data = '1;
      case (ptr)
         W'(REG_IN):  rd_data = pin_s ^ pol_q;
         W'(REG_OUT): rd_data = out_q;
         W'(REG_POL): rd_data = pol_q;
         W'(REG_CFG): rd_data = cfg_q;
         default:     rd_data = '1;
      endcase
   end

   assign port_out = out_q;
   assign port_oe  = ~cfg_q;

   // R8
   in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ptr == W'(REG_IN)) |=> $stable(out_q) && $stable(pol_q) && $stable(cfg_q));

   // R9
   oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ptr_ok) |=> $stable(out_q) && $stable(pol_q) && $stable(cfg_q));

   // R6
   dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ptr == W'(REG_CFG)) |=> (port_oe == ~$past(wr_data)));

endmodule

// File: rtl/ioexp_target.sv
module ioexp_target #(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [5:0]  ADDR_HI     = 6'b010000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              addr_sel,
   input  logic [PORT_W-1:0] port_in,
   output logic [PORT_W-1:0] port_out,
   output logic [PORT_W-1:0] port_oe
);

   if (PORT_W != 8) begin : g_bad_width
      $error("ioexp_target: PORT_W must be 8 (one bus byte per register)");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ioexp_target: SYNC_STAGES must be at least 2");
   end

   logic [1:0]        line_s;
   logic              scl_s, sda_s;
   logic              scl_rise, scl_fall, start_det, stop_det;
   logic [PORT_W-1:0] pin_s, rd_data, ptr, wr_data;
   logic              wr_en;

   ioexp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_line_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (line_s)
   );
   assign scl_s = line_s[1];
   assign sda_s = line_s[0];

   ioexp_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_V(1'b0)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (port_in),
      .q_o   (pin_s)
   );

   ioexp_linecond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   ioexp_busfsm #(.W(PORT_W), .ADDR_HI(ADDR_HI)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_sel  (addr_sel),
      .rd_data   (rd_data),
      .ptr       (ptr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .sda_oe    (sda_oe)
   );

   ioexp_regs #(.W(PORT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .ptr      (ptr),
      .wr_data  (wr_data),
      .pin_s    (pin_s),
      .rd_data  (rd_data),
      .port_out (port_out),
      .port_oe  (port_oe)
   );

endmodule

// File: tb/ioexp_target_bench.sv
`timescale 1ns/1ps
module ioexp_target_bench;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       addr_sel = 1'b0;
   logic [7:0] port_in = 8'h00;
   logic       sda_oe;
   logic [7:0] port_out, port_oe;
   logic       sda_line;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [7:0] m_out = 8'hFF;
   logic [7:0] m_pol = 8'h00;
   logic [7:0] m_cfg = 8'hFF;

   logic mon_en = 1'b0;
   logic oe_seen = 1'b0;
   logic prev_oe = 1'b0;
   int   viol = 0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   ioexp_target u_ioexp_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .addr_sel (addr_sel),
      .port_in  (port_in),
      .port_out (port_out),
      .port_oe  (port_oe)
   );

   always @(posedge clk) begin
      prev_oe <= sda_oe;
      if (rst_n && sda_oe && !prev_oe && scl_m) viol <= viol + 1;
      if (mon_en && sda_oe) oe_seen <= 1'b1;
   end

   function automatic logic [7:0] exp_read(input logic [7:0] p);
      case (p)
         8'd0: return port_in ^ m_pol;
         8'd1: return m_out;
         8'd2: return m_pol;
         8'd3: return m_cfg;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; scl_m = 1'b1; qw();
      sda_m = 1'b0; qw();
      scl_m = 1'b0; qw();
   endtask

   task automatic i2c_rstart();
      sda_m = 1'b1; qw();
      scl_m = 1'b1; qw();
      sda_m = 1'b0; qw();
      scl_m = 1'b0; qw();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; qw();
      scl_m = 1'b1; qw();
      sda_m = 1'b1; qw();
   endtask

   task automatic wbit(input logic b);
      sda_m = b; qw();
      scl_m = 1'b1; qw(); qw();
      scl_m = 1'b0; qw();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) wbit(b[i]);
      sda_m = 1'b1; qw();
      scl_m = 1'b1; qw();
      ack = ~sda_line;
      qw();
      scl_m = 1'b0; qw();
   endtask

   task automatic rd_byte(input logic ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; qw();
         scl_m = 1'b1; qw();
         d[i] = sda_line;
         qw();
         scl_m = 1'b0; qw();
      end
      sda_m = ~ack; qw();
      scl_m = 1'b1; qw(); qw();
      scl_m = 1'b0; qw();
   endtask

   task automatic model_wr(input logic [7:0] p, input logic [7:0] v);
      case (p)
         8'd1: m_out = v;
         8'd2: m_pol = v;
         8'd3: m_cfg = v;
         default: ;
      endcase
   endtask

   task automatic wr_regs(input logic [6:0] a, input logic [7:0] p,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                          input int n, output logic all_ack);
      logic ak;
      logic [7:0] dv;
      all_ack = 1'b1;
      i2c_start();
      wr_byte({a, 1'b0}, ak); all_ack &= ak;
      wr_byte(p, ak); all_ack &= ak;
      for (int i = 0; i < n; i++) begin
         dv = (i == 0) ? d0 : (i == 1) ? d1 : d2;
         wr_byte(dv, ak); all_ack &= ak;
      end
      i2c_stop();
   endtask

   task automatic rd_regs(input logic [6:0] a, input logic [7:0] p, input int n,
                          output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2,
                          output logic all_ack);
      logic ak;
      logic [7:0] d;
      all_ack = 1'b1;
      r0 = 8'h00; r1 = 8'h00; r2 = 8'h00;
      i2c_start();
      wr_byte({a, 1'b0}, ak); all_ack &= ak;
      wr_byte(p, ak); all_ack &= ak;
      i2c_rstart();
      wr_byte({a, 1'b1}, ak); all_ack &= ak;
      for (int i = 0; i < n; i++) begin
         rd_byte(i != n - 1, d);
         if (i == 0) r0 = d; else if (i == 1) r1 = d; else r2 = d;
      end
      i2c_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic ok;
      logic [7:0] r0, r1, r2;
      logic [7:0] p, v;
      int n;

      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk(port_out == 8'hFF, "R1 port_out", port_out, 8'hFF);
      chk(port_oe == 8'h00, "R1 port_oe", port_oe, 8'h00);
      chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);

      // R3 R6 direction write
      wr_regs(7'h20, 8'd3, 8'h0F, 8'h00, 8'h00, 1, ok); model_wr(3, 8'h0F);
      chk(ok, "R3 ack", ok, 1);
      chk(port_oe == 8'hF0, "R6 port_oe", port_oe, 8'hF0);

      // R4 burst to output register, pointer fixed
      wr_regs(7'h20, 8'd1, 8'h11, 8'h22, 8'hA5, 3, ok); model_wr(1, 8'hA5);
      chk(ok, "R4 ack", ok, 1);
      chk(port_out == 8'hA5, "R4 port_out", port_out, 8'hA5);
      rd_regs(7'h20, 8'd3, 1, r0, r1, r2, ok);
      chk(r0 == 8'h0F, "R4 direction untouched", r0, 8'h0F);
      rd_regs(7'h20, 8'd2, 1, r0, r1, r2, ok);
      chk(r0 == 8'h00, "R4 polarity untouched", r0, 8'h00);

      // R5 repeated read of one register
      rd_regs(7'h20, 8'd1, 3, r0, r1, r2, ok);
      chk(ok, "R5 ack", ok, 1);
      chk(r0 == 8'hA5 && r1 == 8'hA5 && r2 == 8'hA5, "R5 repeat read", {r0, r1, r2}, 24'hA5A5A5);

      // R7 polarity inversion on input
      wr_regs(7'h20, 8'd2, 8'h3C, 8'h00, 8'h00, 1, ok); model_wr(2, 8'h3C);
      port_in = 8'h96;
      rd_regs(7'h20, 8'd0, 1, r0, r1, r2, ok);
      chk(r0 == 8'hAA, "R7 input xor polarity", r0, 8'hAA);

      // R8 write to input register
      wr_regs(7'h20, 8'd0, 8'h55, 8'h00, 8'h00, 1, ok);
      chk(ok, "R8 ack", ok, 1);
      rd_regs(7'h20, 8'd0, 1, r0, r1, r2, ok);
      chk(r0 == 8'hAA, "R8 input unchanged", r0, 8'hAA);
      chk(port_out == 8'hA5 && port_oe == 8'hF0, "R8 port unchanged", {port_out, port_oe}, 16'hA5F0);

      // R9 pointer out of range
      wr_regs(7'h20, 8'd7, 8'h12, 8'h00, 8'h00, 1, ok);
      chk(ok, "R9 ack", ok, 1);
      chk(port_out == 8'hA5 && port_oe == 8'hF0, "R9 port unchanged", {port_out, port_oe}, 16'hA5F0);
      rd_regs(7'h20, 8'd7, 2, r0, r1, r2, ok);
      chk(r0 == 8'hFF && r1 == 8'hFF, "R9 read FF", {r0, r1}, 16'hFFFF);
      rd_regs(7'h20, 8'd2, 1, r0, r1, r2, ok);
      chk(r0 == 8'h3C, "R9 polarity untouched", r0, 8'h3C);

      // R2 address matching with both addr_sel values
      wr_regs(7'h21, 8'd1, 8'h00, 8'h00, 8'h00, 1, ok);
      chk(!ok, "R2 foreign nack", ok, 0);
      chk(port_out == 8'hA5, "R2 foreign ignored", port_out, 8'hA5);
      wr_regs(7'h45, 8'd1, 8'h00, 8'h00, 8'h00, 1, ok);
      chk(!ok && port_out == 8'hA5, "R2 other addr", {ok, port_out}, 9'h0A5);
      addr_sel = 1'b1;
      repeat (4) @(negedge clk);
      wr_regs(7'h21, 8'd1, 8'h3E, 8'h00, 8'h00, 1, ok); model_wr(1, 8'h3E);
      chk(ok && port_out == 8'h3E, "R2 addr_sel high", {ok, port_out}, 9'h13E);
      wr_regs(7'h20, 8'd1, 8'h00, 8'h00, 8'h00, 1, ok);
      chk(!ok && port_out == 8'h3E, "R2 low addr rejected", {ok, port_out}, 9'h03E);
      addr_sel = 1'b0;
      repeat (4) @(negedge clk);

      // R10 STOP in mid address and mid data byte
      i2c_start();
      wbit(1'b0); wbit(1'b1); wbit(1'b0); wbit(1'b0);
      i2c_stop();
      chk(sda_oe == 1'b0, "R10 idle after stop", sda_oe, 0);
      i2c_start();
      wr_byte(8'h40, ok);
      wr_byte(8'h01, ok);
      wbit(1'b0); wbit(1'b0); wbit(1'b0); wbit(1'b0);
      i2c_stop();
      chk(port_out == 8'h3E, "R10 cut byte not written", port_out, 8'h3E);
      rd_regs(7'h20, 8'd1, 1, r0, r1, r2, ok);
      chk(ok && r0 == 8'h3E, "R10 next transfer", {ok, r0}, 9'h13E);

      // R11 release after master NACK
      i2c_start();
      wr_byte(8'h40, ok);
      wr_byte(8'h03, ok);
      i2c_rstart();
      wr_byte(8'h41, ok);
      rd_byte(1'b0, r0);
      oe_seen = 1'b0;
      mon_en = 1'b1;
      rd_byte(1'b0, r1);
      mon_en = 1'b0;
      i2c_stop();
      chk(r0 == 8'h0F, "R11 first byte", r0, 8'h0F);
      chk(!oe_seen && r1 == 8'hFF, "R11 released", {oe_seen, r1}, 9'h0FF);

      // random traffic against model
      for (int it = 0; it < 24; it++) begin
         p = 8'($urandom_range(1, 3));
         n = $urandom_range(1, 3);
         v = 8'($urandom);
         r1 = 8'($urandom);
         r2 = 8'($urandom);
         wr_regs(7'h20, p, r1, r2, v, n, ok);
         model_wr(p, (n == 1) ? r1 : (n == 2) ? r2 : v);
         chk(ok, "R4 random ack", ok, 1);
         port_in = 8'($urandom);
         repeat (4) @(negedge clk);
         p = 8'($urandom_range(0, 4));
         rd_regs(7'h20, p, 2, r0, r1, r2, ok);
         chk(r0 == exp_read(p) && r1 == exp_read(p), "R5 random read", {r0, r1}, {exp_read(p), exp_read(p)});
         chk(port_out == m_out && port_oe == ~m_cfg, "R6 random port", {port_out, port_oe}, {m_out, ~m_cfg});
      end

      // R12 driving only starts while SCL low
      chk(viol == 0, "R12 drive timing", viol, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule